// File: doc/BRIEF.md
# Banked Byte-Read Nonvolatile ROM

This block models a 1 kbit nonvolatile store split into eight banks of sixteen bytes. Core logic reads one byte at a time through a synchronous port. A 7-bit address is sampled on a rising clock edge, and the byte appears on the following falling edge. The valid flag is low in the first half of every cycle and high in the second half, even when the address does not change. The consumer must take the byte while the flag is high. The read port has no back-pressure and does not hold a byte for a slow consumer.

A separate programming port stands in for a serial test-port loader. It rewrites whole banks only. A start strobe captures an 8-bit bank select mask and one 128-bit image. Each selected bank is then erased to all ones and written with the image, one bank after another in ascending order. The start strobe has no handshake. While busy is high, further strobes are refused and the caller has to wait for done. A bank under rework reads as all ones with the flag low, and the other banks stay readable. At reset the array is loaded from a parameter vector, which stands for the contents kept while power is off.

Top module: `nvrom_top`

## Requirements
- R1: After reset, rd_valid_o, busy_o and done_o are low. The byte at address a is bits [8a+7:8a] of the INIT_IMAGE parameter. The default image holds a XOR 0xA5 at byte a.
- R2: Address bits [6:4] pick the bank and bits [3:0] pick the byte within that bank.
- R3: The address is sampled at a rising edge, and the byte is driven at the next falling edge with rd_valid_o high. rd_valid_o is low from every rising edge until the next falling edge, even when the address is held.
- R4: Programming a bank makes its byte k equal to prog_image_i[8k+7:8k]. Banks that were not selected keep their contents.
- R5: Bit b of prog_mask_i selects bank b. The selected banks are reworked one at a time, lowest number first.
- R6: A start with an all-zero mask reworks only the single bank named by prog_bank_i.
- R7: A start taken while idle raises busy_o from the next cycle. busy_o then stays high for exactly n*(ERASE_CYC+WRITE_CYC) cycles for n selected banks.
- R8: done_o is high for exactly one cycle, in the cycle right after busy_o falls. It is never high together with busy_o.
- R9: A start that arrives while busy_o is high is ignored. It changes no contents and does not lengthen the busy period.
- R10: A read from the bank that is being erased or written returns 0xFF with rd_valid_o low. Reads from other banks return their stored bytes with the normal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the read and programming logic |
| rst_ni | input | 1 | Asynchronous active-low reset, reloads the contents |
| rd_addr_i | input | 7 | Byte address: bank in [6:4], byte in [3:0] |
| rd_data_o | output | 8 | Byte read, updated on the falling edge |
| rd_valid_o | output | 1 | High in the second half-cycle when rd_data_o holds a good byte |
| prog_start_i | input | 1 | Starts a programming sequence when idle |
| prog_mask_i | input | 8 | One select bit per bank |
| prog_bank_i | input | 3 | Bank to use when the mask is zero |
| prog_image_i | input | 128 | Image written into each selected bank |
| busy_o | output | 1 | High while any bank is being erased or written |
| done_o | output | 1 | One-cycle pulse after the last bank is finished |

## Verification
A read result is due half a cycle after the rising edge that samples the address. The bench drives the address 1 ns after one rising edge. It checks that the flag is low 1 ns after the next rising edge, then checks the byte and the flag 1 ns after the falling edge that follows. Programming results depend on counted cycles, with ERASE_CYC+WRITE_CYC cycles per bank. A falling-edge monitor counts the busy and done cycles, and the bench compares those counts with the values the requirements give. To test read lockout and the order of banks during a multi-bank run, the bench issues each read on a known cycle after the start edge, so it knows which bank is locked when that read is sampled.

// File: rtl/nvrom_pkg.sv
package nvrom_pkg;
  localparam int NV_BANKS     = 8;
  localparam int NV_BANK_BYTES = 16;
  localparam int NV_BYTE_W    = 8;
  localparam int NV_TOTAL_W   = NV_BANKS * NV_BANK_BYTES * NV_BYTE_W;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ERASE,
    SEQ_WRITE,
    SEQ_DONE
  } seq_state_t;

  // Default retained contents: byte at address a holds a ^ 8'hA5.
  function automatic logic [NV_TOTAL_W-1:0] default_image();
    logic [NV_TOTAL_W-1:0] img;
    img = '0;
    for (int a = 0; a < NV_BANKS * NV_BANK_BYTES; a++) begin
      img[a*NV_BYTE_W +: NV_BYTE_W] = 8'(a) ^ 8'hA5;
    end
    return img;
  endfunction
endpackage

// File: rtl/nvrom_store.sv
module nvrom_store #(
  parameter int BANKS      = 8,
  parameter int BANK_BYTES = 16,
  parameter int BYTE_W     = 8,
  parameter logic [BANKS*BANK_BYTES*BYTE_W-1:0] INIT = '0,
  localparam int BANK_W = BANK_BYTES * BYTE_W,
  localparam int BAW    = $clog2(BANKS),
  localparam int BYW    = $clog2(BANK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_en,
  input  logic              wr_en,
  input  logic [BAW-1:0]    sel_bank,
  input  logic [BANK_W-1:0] wr_img,
  input  logic [BAW-1:0]    rd_bank,
  input  logic [BYW-1:0]    rd_byte,
  output logic [BYTE_W-1:0] rd_byte_data
);
  logic [BANK_W-1:0] bank_q [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[b] <= INIT[b*BANK_W +: BANK_W];
      end else if (erase_en && (sel_bank == BAW'(b))) begin
        bank_q[b] <= '1;
      end else if (wr_en && (sel_bank == BAW'(b))) begin
        bank_q[b] <= wr_img;
      end
    end
  end

  logic [BANK_W-1:0] rd_row;
  always_comb begin
    rd_row       = bank_q[rd_bank];
    rd_byte_data = rd_row[rd_byte*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/nvrom_prog_seq.sv
module nvrom_prog_seq
  import nvrom_pkg::*;
#(
  parameter int BANKS     = 8,
  parameter int BANK_W    = 128,
  parameter int ERASE_CYC = 4,
  parameter int WRITE_CYC = 3,
  localparam int BAW = $clog2(BANKS),
  localparam int MAXC = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC,
  localparam int CW  = $clog2(MAXC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BANKS-1:0]  mask,
  input  logic [BAW-1:0]    bank,
  input  logic [BANK_W-1:0] image,
  output logic              busy,
  output logic              done,
  output logic              erase_en,
  output logic              wr_en,
  output logic [BAW-1:0]    cur_bank,
  output logic [BANK_W-1:0] img_q,
  output logic [BANKS-1:0]  lock
);
  seq_state_t        state_q;
  logic [BANKS-1:0]  pend_q, eff_mask, rest;
  logic [CW-1:0]     cnt_q;

  function automatic logic [BAW-1:0] lowest(input logic [BANKS-1:0] v);
    logic [BAW-1:0] r;
    r = '0;
    for (int i = BANKS - 1; i >= 0; i--) begin
      if (v[i]) r = BAW'(i);
    end
    return r;
  endfunction

  always_comb begin
    eff_mask = (mask != '0) ? mask : (BANKS'(1) << bank);
    rest     = pend_q & ~(BANKS'(1) << cur_bank);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      pend_q   <= '0;
      cur_bank <= '0;
      cnt_q    <= '0;
      img_q    <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            pend_q   <= eff_mask;
            cur_bank <= lowest(eff_mask);
            cnt_q    <= '0;
            img_q    <= image;
            state_q  <= SEQ_ERASE;
          end
        end
        SEQ_ERASE: begin
          if (cnt_q == CW'(ERASE_CYC - 1)) begin
            cnt_q   <= '0;
            state_q <= SEQ_WRITE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_WRITE: begin
          if (cnt_q == CW'(WRITE_CYC - 1)) begin
            cnt_q  <= '0;
            pend_q <= rest;
            if (rest != '0) begin
              cur_bank <= lowest(rest);
              state_q  <= SEQ_ERASE;
            end else begin
              state_q <= SEQ_DONE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_DONE: state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    erase_en = (state_q == SEQ_ERASE);
    wr_en    = (state_q == SEQ_WRITE) && (cnt_q == CW'(WRITE_CYC - 1));
    busy     = (state_q == SEQ_ERASE) || (state_q == SEQ_WRITE);
    done     = (state_q == SEQ_DONE);
    lock     = busy ? (BANKS'(1) << cur_bank) : '0;
  end
endmodule

// File: rtl/nvrom_rdport.sv
module nvrom_rdport #(
  parameter int BANKS  = 8,
  parameter int ADDR_W = 7,
  parameter int BYTE_W = 8,
  localparam int BAW = $clog2(BANKS),
  localparam int BYW = ADDR_W - BAW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANKS-1:0]  lock,
  input  logic [BYTE_W-1:0] mem_byte,
  output logic [BAW-1:0]    rd_bank,
  output logic [BYW-1:0]    rd_byte,
  output logic [BYTE_W-1:0] data,
  output logic              valid
);
  logic [ADDR_W-1:0] addr_q;
  logic              rise_ph, fall_ph, ok_q;

  // Rising edge: capture address and flip the phase marker.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rise_ph <= 1'b0;
    end else begin
      addr_q  <= addr;
      rise_ph <= ~rise_ph;
    end
  end

  assign rd_bank = addr_q[ADDR_W-1 -: BAW];
  assign rd_byte = addr_q[BYW-1:0];

  // Falling edge: present the byte and realign the phase marker.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_ph <= 1'b0;
      ok_q    <= 1'b0;
      data    <= '1;
    end else begin
      fall_ph <= rise_ph;
      ok_q    <= ~lock[rd_bank];
      data    <= lock[rd_bank] ? '1 : mem_byte;
    end
  end

  assign valid = ok_q && (rise_ph == fall_ph);
endmodule

// File: rtl/nvrom_top.sv
module nvrom_top
  import nvrom_pkg::*;
#(
  parameter int BANKS      = NV_BANKS,
  parameter int BANK_BYTES = NV_BANK_BYTES,
  parameter int BYTE_W     = NV_BYTE_W,
  parameter int ERASE_CYC  = 4,
  parameter int WRITE_CYC  = 3,
  parameter logic [BANKS*BANK_BYTES*BYTE_W-1:0] INIT_IMAGE = default_image(),
  localparam int BANK_W = BANK_BYTES * BYTE_W,
  localparam int BAW    = $clog2(BANKS),
  localparam int BYW    = $clog2(BANK_BYTES),
  localparam int ADDR_W = BAW + BYW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  input  logic              prog_start_i,
  input  logic [BANKS-1:0]  prog_mask_i,
  input  logic [BAW-1:0]    prog_bank_i,
  input  logic [BANK_W-1:0] prog_image_i,
  output logic              busy_o,
  output logic              done_o
);
  logic              erase_en, wr_en;
  logic [BAW-1:0]    cur_bank, rd_bank;
  logic [BYW-1:0]    rd_byte;
  logic [BANK_W-1:0] img_q;
  logic [BANKS-1:0]  bank_lock;
  logic [BYTE_W-1:0] mem_byte;

  nvrom_prog_seq #(
    .BANKS(BANKS), .BANK_W(BANK_W),
    .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)
  ) u_seq (
    .clk(clk_i), .rst_n(rst_ni),
    .start(prog_start_i), .mask(prog_mask_i), .bank(prog_bank_i),
    .image(prog_image_i),
    .busy(busy_o), .done(done_o),
    .erase_en(erase_en), .wr_en(wr_en),
    .cur_bank(cur_bank), .img_q(img_q), .lock(bank_lock)
  );

  nvrom_store #(
    .BANKS(BANKS), .BANK_BYTES(BANK_BYTES), .BYTE_W(BYTE_W), .INIT(INIT_IMAGE)
  ) u_store (
    .clk(clk_i), .rst_n(rst_ni),
    .erase_en(erase_en), .wr_en(wr_en), .sel_bank(cur_bank), .wr_img(img_q),
    .rd_bank(rd_bank), .rd_byte(rd_byte), .rd_byte_data(mem_byte)
  );

  nvrom_rdport #(
    .BANKS(BANKS), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)
  ) u_rd (
    .clk(clk_i), .rst_n(rst_ni),
    .addr(rd_addr_i), .lock(bank_lock), .mem_byte(mem_byte),
    .rd_bank(rd_bank), .rd_byte(rd_byte),
    .data(rd_data_o), .valid(rd_valid_o)
  );
endmodule

// File: rtl/nvrom_checks.sv
module nvrom_checks #(
  parameter int BANKS = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_valid_o,
  input logic             prog_start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [BANKS-1:0] bank_lock
);
  // R3: just before each falling edge the flag is still low (first half-cycle)
  p_valid_low_first_half_r3: assert property (
    @(negedge clk_i) disable iff (!rst_ni) !rd_valid_o);

  // R7: an accepted start raises busy in the next cycle
  p_start_raises_busy_r7: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
      (prog_start_i && !busy_o && !done_o) |=> busy_o);

  // R8: done lasts a single cycle
  p_done_single_r8: assert property (
    @(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o);

  // R8: done follows the fall of busy
  p_done_after_busy_r8: assert property (
    @(posedge clk_i) disable iff (!rst_ni) $fell(busy_o) |-> done_o);

  // R8: done and busy never overlap
  p_done_not_busy_r8: assert property (
    @(posedge clk_i) disable iff (!rst_ni) done_o |-> !busy_o);

  // R10: at most one bank is locked, and only while busy
  p_lock_single_r10: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
      $onehot0(bank_lock) && (busy_o || bank_lock == '0));
endmodule

bind nvrom_top nvrom_checks #(.BANKS(BANKS)) u_checks (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_valid_o(rd_valid_o),
  .prog_start_i(prog_start_i), .busy_o(busy_o), .done_o(done_o),
  .bank_lock(bank_lock)
);

// File: tb/nvrom_top_test.sv
module nvrom_top_test;
  localparam int EC = 4;
  localparam int WC = 3;
  localparam int PER_BANK = EC + WC;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [6:0]   rd_addr = '0;
  logic [7:0]   rd_data;
  logic         rd_valid;
  logic         start = 1'b0;
  logic [7:0]   mask = '0;
  logic [2:0]   bank = '0;
  logic [127:0] image = '0;
  logic         busy, done;

  int n_chk = 0;
  int n_bad = 0;
  int busy_total = 0;
  int done_total = 0;

  always #4 clk = ~clk;

  nvrom_top #(.ERASE_CYC(EC), .WRITE_CYC(WC)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .prog_start_i(start), .prog_mask_i(mask), .prog_bank_i(bank),
    .prog_image_i(image), .busy_o(busy), .done_o(done)
  );

  always @(negedge clk) begin
    if (busy) busy_total++;
    if (done) done_total++;
  end

  function automatic logic [7:0] init_byte(input logic [6:0] a);
    return 8'(a) ^ 8'hA5;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Issue address now (after a rising edge), check both half-cycles.
  task automatic rd(input logic [6:0] a, input logic [7:0] exp, input logic expv,
                    input string req);
    rd_addr = a;
    @(posedge clk); #1;
    check({req, " R3 first-half flag"}, rd_valid, 0);
    @(negedge clk); #1;
    check({req, " flag"}, rd_valid, expv);
    check({req, " data"}, rd_data, expv ? exp : 8'hFF);
  endtask

  task automatic prog(input logic [7:0] m, input logic [2:0] b, input logic [127:0] img);
    mask = m; bank = b; image = img; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    while (!done) begin @(posedge clk); #1; end
    @(posedge clk); #1;
  endtask

  localparam logic [14:0] VEC [8] = '{
    {7'h00, 8'hA5}, {7'h7F, 8'hDA}, {7'h10, 8'hB5}, {7'h35, 8'h90},
    {7'h4A, 8'hEF}, {7'h6C, 8'hC9}, {7'h0F, 8'hAA}, {7'h71, 8'hD4}
  };

  localparam logic [127:0] IMG_A = 128'h00112233445566778899AABBCCDDEEFF;
  localparam logic [127:0] IMG_B = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
  localparam logic [127:0] IMG_C = 128'hDEADBEEF0123456789ABCDEFFEDCBA98;

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0x0 expected 0x1 (run did not finish)");
    summary();
  end

  initial begin
    int b0, d0;
    // R1: reset state
    #13;
    check("R1 valid in reset", rd_valid, 0);
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(posedge clk); #1;

    // R1/R2/R3: table of retained contents
    foreach (VEC[i]) begin
      rd(VEC[i][14:8], VEC[i][7:0], 1'b1, "R1 R2 table");
    end
    // R3: held address keeps toggling the flag
    for (int k = 0; k < 3; k++) rd(7'h35, 8'h90, 1'b1, "R3 held address");

    // R4/R7/R8: single bank via mask
    b0 = busy_total; d0 = done_total;
    prog(8'b0000_0100, 3'd0, IMG_A);
    check("R7 busy cycles one bank", busy_total - b0, PER_BANK);
    check("R8 done cycles", done_total - d0, 1);
    for (int k = 0; k < 16; k++) rd(7'(32 + k), IMG_A[k*8 +: 8], 1'b1, "R4 new bank2");
    rd(7'h1F, init_byte(7'h1F), 1'b1, "R4 bank1 kept");
    rd(7'h30, init_byte(7'h30), 1'b1, "R4 bank3 kept");

    // R6: zero mask uses bank number
    b0 = busy_total;
    prog(8'h00, 3'd6, IMG_C);
    check("R6 busy cycles", busy_total - b0, PER_BANK);
    rd(7'h63, IMG_C[3*8 +: 8], 1'b1, "R6 bank6 written");
    rd(7'h53, init_byte(7'h53), 1'b1, "R6 bank5 kept");

    // R5/R9/R10: three banks, ascending order, concurrent reads
    b0 = busy_total; d0 = done_total;
    mask = 8'b1001_0001; image = IMG_B; start = 1'b1;
    rd(7'h02, 8'hFF, 1'b0, "R10 bank0 locked first");        // sampled E0
    mask = 8'b0000_0010; start = 1'b1;                       // R9: ignored
    rd(7'h45, init_byte(7'h45), 1'b1, "R5 R10 bank4 not yet"); // sampled E1
    start = 1'b0;
    repeat (13) @(posedge clk);
    #1;
    rd(7'h7A, 8'hFF, 1'b0, "R5 bank7 locked last");          // sampled E15
    rd(7'h02, IMG_B[2*8 +: 8], 1'b1, "R5 bank0 already new"); // sampled E16
    while (!done) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    check("R7 busy cycles three banks", busy_total - b0, 3 * PER_BANK);
    check("R8 single done", done_total - d0, 1);
    rd(7'h4E, IMG_B[14*8 +: 8], 1'b1, "R5 bank4 new");
    rd(7'h70, IMG_B[7:0], 1'b1, "R5 bank7 new");
    rd(7'h11, init_byte(7'h11), 1'b1, "R9 bank1 untouched");
    rd(7'h25, IMG_A[5*8 +: 8], 1'b1, "R4 bank2 kept");

    // R1: reset reloads retained image
    rst_n = 1'b0;
    #3;
    check("R1 busy low in reset", busy, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(posedge clk); #1;
    rd(7'h22, init_byte(7'h22), 1'b1, "R1 reload");
    summary();
  end
endmodule